// File: doc/BRIEF.md
# Digital IF Quadrature Downconverter

This block turns a stream of real, signed IF samples from a radar receiver's converter into complex baseband words. Every accepted sample is multiplied by a locally generated sine and cosine at the IF rate, with the references scaled by two. Each pair of consecutive products is averaged, which acts as a decimate-by-two low-pass filter. The average is rounded, clipped to eight bits and packed into one 16-bit word per range bin for the clutter canceller that follows.

The local phase comes from an accumulator that steps by `PHASE_INC` (the IF-to-sample-rate ratio times the table size) for each accepted sample. It restarts at zero on every sample flagged as the start of a pulse. A pulse holds `2*NBINS` samples and gives `NBINS` output words. Samples that arrive after a pulse is complete, or before the first pulse start, are dropped.

Top module: `iq_downconv`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: The j-th accepted sample of a pulse (j counted from 0) uses table index k = (j·PHASE_INC) mod 2^PHASE_W. The sine reference is S(k) = round-half-away(127·sin(2πk/2^PHASE_W)), and the cosine reference is S((k + 2^PHASE_W/4) mod 2^PHASE_W).
- R3: The real product of a sample x is −2·x·sine reference, and the imaginary product is +2·x·cosine reference.
- R4: Within a pulse, samples (0,1), (2,3), … form pairs. Exactly one output word is produced per completed pair. Each field is floor((p_even + p_odd + 128) / 256), taken over that field's two products.
- R5: Each field is clipped to the range −128..127 before packing.
- R6: `out_data[15:8]` holds the real part and `out_data[7:0]` holds the imaginary part, both two's complement.
- R7: `out_valid` goes high for one cycle. It is updated on the second rising edge after the edge that accepts the odd sample of a pair.
- R8: A sample with `in_start` high is taken as index 0 whatever came before, and any incomplete pair is discarded.
- R9: Samples that have `in_valid` high but `in_start` low produce no output in two cases: before any pulse start since reset, and after `2*NBINS` samples of the current pulse.
- R10: A pure tone at a quarter of the sample rate (PHASE_INC = 2^PHASE_W/4) gives a constant phasor over the pulse. Its value is about (0.99·A·sin φ, 0.99·A·cos φ) for amplitude A and phase φ, within 2 LSB.
- R11: While `out_valid` is low, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_start | input | 1 | Sample is the first of a pulse (used only with in_valid) |
| in_sample | input | 8 | Signed IF sample |
| out_valid | output | 1 | Output word valid this cycle |
| out_data | output | 16 | Packed word: real in [15:8], imaginary in [7:0] |

## Verification
The bound checker watches four things on every cycle. It checks that each odd accepted sample yields a valid word exactly at the fixed latency, and that no word appears without one. It checks that ignored samples produce nothing, and that the output word holds between valid pulses. The numeric content needs the bench scenarios. These cover the phase stepping and wrap of the table index, the mixer signs, pair averaging with rounding, clipping at full scale, field order, restarts in the middle of a pair, and the constant phasor from a quarter-rate tone.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int ADC_W  = 8;
    localparam int REF_W  = 8;
    localparam int OUT_W  = 8;
    localparam int PROD_W = ADC_W + REF_W + 1;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SHIFT  = REF_W;

    typedef logic signed [ADC_W-1:0]  adc_t;
    typedef logic signed [REF_W-1:0]  ref_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [OUT_W-1:0]  out_t;

    typedef struct packed {
        logic valid;
        logic odd;
        adc_t x;
        ref_t sin_v;
        ref_t cos_v;
    } mix_in_t;

    typedef struct packed {
        logic  valid;
        logic  odd;
        prod_t re;
        prod_t im;
    } prod_pair_t;

    typedef struct packed {
        out_t re;
        out_t im;
    } iq_word_t;

    // Reference level for table entry k of depth entries, rounded half away from zero.
    function automatic int ref_level(int k, int depth);
        real ang;
        real r;
        ang = 2.0 * 3.14159265358979 * real'(k) / real'(depth);
        r   = real'((1 << (REF_W - 1)) - 1) * $sin(ang);
        if (r >= 0.0)
            return $rtoi(r + 0.5);
        else
            return -$rtoi(-r + 0.5);
    endfunction

    // Round (half up) the pair sum down by SHIFT bits and clip to OUT_W bits.
    function automatic out_t round_sat(sum_t s);
        logic signed [SUM_W:0] r;
        logic signed [SUM_W:0] omax;
        logic signed [SUM_W:0] rnd;
        omax = (SUM_W+1)'((1 << (OUT_W - 1)) - 1);
        rnd  = (SUM_W+1)'(1 << (SHIFT - 1));
        r    = $signed({s[SUM_W-1], s}) + rnd;
        r    = r >>> SHIFT;
        if (r > omax)
            r = omax;
        else if (r < ~omax)
            r = ~omax;
        return r[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/iq_nco.sv
module iq_nco #(
    parameter int PHASE_W   = 6,
    parameter int PHASE_INC = 3,
    parameter int NBINS     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_start,
    output logic               take,
    output logic               odd,
    output logic [PHASE_W-1:0] phase
);
    localparam int CNT_W = $clog2(2 * NBINS + 1);
    localparam logic [CNT_W-1:0]   LEN  = CNT_W'(2 * NBINS);
    localparam logic [PHASE_W-1:0] STEP = PHASE_W'(PHASE_INC);

    logic               armed_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PHASE_W-1:0] acc_q;
    logic [CNT_W-1:0]   idx;

    assign take  = in_valid && (in_start || (armed_q && (cnt_q < LEN)));
    assign idx   = in_start ? '0 : cnt_q;
    assign phase = in_start ? '0 : acc_q;
    assign odd   = idx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else if (take) begin
            armed_q <= 1'b1;
            cnt_q   <= idx + CNT_W'(1);
            acc_q   <= phase + STEP;
        end
    end
endmodule

// File: rtl/iq_sincos.sv
module iq_sincos
    import iq_pkg::*;
#(
    parameter int PHASE_W = 6
) (
    input  logic [PHASE_W-1:0] phase,
    output ref_t               sin_v,
    output ref_t               cos_v
);
    localparam int DEPTH = 1 << PHASE_W;
    localparam logic [PHASE_W-1:0] QTR = PHASE_W'(DEPTH / 4);

    ref_t sin_tab [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        localparam int LV = ref_level(k, DEPTH);
        assign sin_tab[k] = ref_t'(LV);
    end

    logic [PHASE_W-1:0] cos_idx;
    assign cos_idx = phase + QTR;
    assign sin_v   = sin_tab[phase];
    assign cos_v   = sin_tab[cos_idx];
endmodule

// File: rtl/iq_mixer.sv
module iq_mixer
    import iq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mix_in_t    d,
    output prod_pair_t q
);
    prod_t xs;
    prod_t xc;
    prod_t re_c;
    prod_t im_c;

    always_comb begin
        xs   = prod_t'(d.x) * prod_t'(d.sin_v);
        xc   = prod_t'(d.x) * prod_t'(d.cos_v);
        re_c = -(xs <<< 1);
        im_c = xc <<< 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= d.valid;
            q.odd   <= d.odd;
            q.re    <= re_c;
            q.im    <= im_c;
        end
    end
endmodule

// File: rtl/iq_pairavg.sv
module iq_pairavg
    import iq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  prod_pair_t d,
    output logic       out_valid,
    output iq_word_t   out_word
);
    prod_t hold_re;
    prod_t hold_im;
    sum_t  sum_re;
    sum_t  sum_im;

    always_comb begin
        sum_re = sum_t'(hold_re) + sum_t'(d.re);
        sum_im = sum_t'(hold_im) + sum_t'(d.im);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_re   <= '0;
            hold_im   <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (d.valid) begin
                if (!d.odd) begin
                    hold_re <= d.re;
                    hold_im <= d.im;
                end else begin
                    out_valid   <= 1'b1;
                    out_word.re <= round_sat(sum_re);
                    out_word.im <= round_sat(sum_im);
                end
            end
        end
    end
endmodule

// File: rtl/iq_downconv.sv
module iq_downconv
    import iq_pkg::*;
#(
    parameter int PHASE_W   = 6,
    parameter int PHASE_INC = 3,
    parameter int NBINS     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_start,
    input  logic signed [ADC_W-1:0] in_sample,
    output logic                   out_valid,
    output logic [2*OUT_W-1:0]     out_data
);
    logic               take;
    logic               odd;
    logic [PHASE_W-1:0] phase;
    ref_t               sin_v;
    ref_t               cos_v;
    mix_in_t            s1_d;
    mix_in_t            s1_q;
    prod_pair_t         s2_q;
    iq_word_t           word;

    iq_nco #(
        .PHASE_W  (PHASE_W),
        .PHASE_INC(PHASE_INC),
        .NBINS    (NBINS)
    ) u_nco (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_start(in_start),
        .take    (take),
        .odd     (odd),
        .phase   (phase)
    );

    iq_sincos #(.PHASE_W(PHASE_W)) u_lut (
        .phase(phase),
        .sin_v(sin_v),
        .cos_v(cos_v)
    );

    always_comb begin
        s1_d.valid = take;
        s1_d.odd   = odd;
        s1_d.x     = in_sample;
        s1_d.sin_v = sin_v;
        s1_d.cos_v = cos_v;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    iq_mixer u_mix (
        .clk(clk),
        .rst(rst),
        .d  (s1_q),
        .q  (s2_q)
    );

    iq_pairavg u_avg (
        .clk      (clk),
        .rst      (rst),
        .d        (s2_q),
        .out_valid(out_valid),
        .out_word (word)
    );

    assign out_data = word;
endmodule

// File: rtl/iq_downconv_chk.sv
module iq_downconv_chk #(
    parameter int NBINS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_start,
    input logic        out_valid,
    input logic [15:0] out_data
);
    logic armed;
    int   seen;
    int   pos;
    logic tk;
    logic tk_odd;

    assign tk     = !rst && in_valid && (in_start || (armed && (seen < 2 * NBINS)));
    assign pos    = in_start ? 0 : seen;
    assign tk_odd = tk && pos[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            seen  <= 0;
        end else if (tk) begin
            armed <= 1'b1;
            seen  <= pos + 1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == 16'h0000));

    assert_pair_latency_R7: assert property (@(posedge clk) disable iff (rst)
        tk_odd |-> ##3 out_valid);

    assert_one_per_pair_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(tk_odd, 3));

    assert_ignored_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tk) |-> ##3 !out_valid);

    assert_word_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

bind iq_downconv iq_downconv_chk #(.NBINS(NBINS)) u_chk (.*);

// File: tb/tb_iq_downconv.sv
module tb_iq_downconv;
    localparam int NB    = 8;
    localparam int PW    = 6;
    localparam int D     = 1 << PW;
    localparam int INC_A = 3;
    localparam int INC_B = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic signed [7:0] in_sample = 8'sd0;
    logic ova, ovb;
    logic [15:0] oda, odb;

    always #5 clk = ~clk;

    iq_downconv #(.PHASE_W(PW), .PHASE_INC(INC_A), .NBINS(NB)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_sample(in_sample), .out_valid(ova), .out_data(oda));

    iq_downconv #(.PHASE_W(PW), .PHASE_INC(INC_B), .NBINS(NB)) dut_q (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_sample(in_sample), .out_valid(ovb), .out_data(odb));

    int checks = 0;
    int fails  = 0;
    int exp_a[$], exp_b[$], got_a[$], got_b[$];
    bit m_armed;
    int m_cnt;
    int h_re[2], h_im[2];

    function automatic int lvl(int k);
        real r;
        r = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k % D) / real'(D));
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int rs(int s);
        int r;
        r = (s + 128) >>> 8;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    function automatic int sbyte(int w);
        logic [7:0] b;
        b = w[7:0];
        return int'($signed(b));
    endfunction

    task automatic check_eq(int act, int expv, string msg);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ova) got_a.push_back(int'(oda));
            if (ovb) got_b.push_back(int'(odb));
        end
    end

    task automatic mix(int inst, int inc, int j, int x);
        int k, pre, pim, w;
        k   = (j * inc) % D;
        pre = -2 * x * lvl(k);
        pim = 2 * x * lvl(k + D / 4);
        if (j % 2 == 0) begin
            h_re[inst] = pre;
            h_im[inst] = pim;
        end else begin
            w = ((rs(h_re[inst] + pre) & 255) << 8) | (rs(h_im[inst] + pim) & 255);
            if (inst == 0) exp_a.push_back(w);
            else           exp_b.push_back(w);
        end
    endtask

    task automatic put(bit v, bit st, int x);
        int j;
        @(negedge clk);
        in_valid  = v;
        in_start  = st;
        in_sample = 8'(x);
        if (v && (st || (m_armed && m_cnt < 2 * NB))) begin
            j       = st ? 0 : m_cnt;
            m_cnt   = j + 1;
            m_armed = 1'b1;
            mix(0, INC_A, j, x);
            mix(1, INC_B, j, x);
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) put(1'b0, 1'b0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        in_start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_armed = 1'b0;
        m_cnt = 0;
        got_a.delete(); got_b.delete(); exp_a.delete(); exp_b.delete();
    endtask

    task automatic compare(string tag);
        int n;
        idle(6);
        check_eq(got_a.size(), exp_a.size(), {tag, " word count (A)"});
        check_eq(got_b.size(), exp_b.size(), {tag, " word count (B)"});
        n = (got_a.size() < exp_a.size()) ? got_a.size() : exp_a.size();
        for (int i = 0; i < n; i++) check_eq(got_a[i], exp_a[i], {tag, " word (A)"});
        n = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
        for (int i = 0; i < n; i++) check_eq(got_b[i], exp_b[i], {tag, " word (B)"});
        got_a.delete(); got_b.delete(); exp_a.delete(); exp_b.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        real phs[4];
        void'($urandom(32'd2024));
        phs[0] = 0.3; phs[1] = 1.2; phs[2] = 2.5; phs[3] = -2.0;

        // R1: state out of reset
        do_reset();
        @(negedge clk);
        check_eq(int'(ova), 0, "R1 out_valid after reset");
        check_eq(int'(oda), 0, "R1 out_data after reset");
        check_eq(int'(ovb), 0, "R1 out_valid after reset (B)");

        // R9: samples before any pulse start are dropped
        for (int i = 0; i < 6; i++) put(1'b1, 1'b0, 50 + i);
        compare("R9 pre-start");

        // R7: latency of one pair
        put(1'b1, 1'b1, 50);
        put(1'b1, 1'b0, -30);
        @(negedge clk); in_valid = 1'b0; in_start = 1'b0;
        check_eq(int'(ova), 0, "R7 not yet valid (edge+0)");
        @(posedge clk); @(negedge clk);
        check_eq(int'(ova), 0, "R7 not yet valid (edge+1)");
        @(posedge clk); @(negedge clk);
        check_eq(int'(ova), 1, "R7 valid at edge+2");
        @(posedge clk); @(negedge clk);
        check_eq(int'(ova), 0, "R7 single cycle valid");
        compare("R7 pair value");

        // R6: field order, quarter-rate instance: re=0x14 im=0x28
        put(1'b1, 1'b1, 40);
        put(1'b1, 1'b0, -20);
        idle(6);
        check_eq((got_b.size() > 0) ? got_b[0] : -1, 16'h1428, "R6 packed real/imag word");
        compare("R6 packing");

        // R5: clipping at full scale
        put(1'b1, 1'b1, -128);
        put(1'b1, 1'b0, -128);
        put(1'b1, 1'b0, 127);
        put(1'b1, 1'b0, 127);
        idle(6);
        check_eq((got_a.size() > 1) ? (got_a[0] & 255) : -1, 8'h80, "R5 clip low");
        check_eq((got_a.size() > 1) ? (got_a[1] & 255) : -1, 8'h7f, "R5 clip high");
        compare("R5 clipping");

        // R8: restart inside a pair
        put(1'b1, 1'b1, 90);
        put(1'b1, 1'b1, 11);
        put(1'b1, 1'b0, 77);
        put(1'b1, 1'b0, -5);
        put(1'b1, 1'b1, 33);
        put(1'b1, 1'b0, 44);
        compare("R8 restart");

        // R9: samples beyond 2N in a pulse are dropped; R4 count per pulse
        put(1'b1, 1'b1, 3);
        for (int i = 1; i < 2 * NB + 5; i++) put(1'b1, 1'b0, i * 7 - 60);
        idle(6);
        check_eq(got_a.size(), NB, "R4 R9 words per full pulse");
        compare("R9 truncation");

        // R10: quarter-rate tone gives a constant phasor
        foreach (phs[p]) begin
            for (int j = 0; j < 2 * NB; j++) begin
                real xr;
                int x;
                xr = 100.0 * $cos(3.14159265358979 * real'(j) / 2.0 + phs[p]);
                x = (xr >= 0.0) ? $rtoi(xr + 0.5) : -$rtoi(-xr + 0.5);
                if (j > 0 && ($urandom % 4) == 0) idle(1);
                put(1'b1, j == 0, x);
            end
            idle(6);
            check_eq(got_b.size(), NB, "R10 tone word count");
            foreach (got_b[i]) begin
                int er, ei;
                er = $rtoi(99.22 * $sin(phs[p]) + 100.5) - 100;
                ei = $rtoi(99.22 * $cos(phs[p]) + 100.5) - 100;
                checks++;
                if (sbyte(got_b[i] >> 8) - er > 2 || er - sbyte(got_b[i] >> 8) > 2 ||
                    sbyte(got_b[i]) - ei > 2 || ei - sbyte(got_b[i]) > 2) begin
                    fails++;
                    $display("FAIL R10 phasor actual=%0d,%0d expected=%0d,%0d",
                             sbyte(got_b[i] >> 8), sbyte(got_b[i]), er, ei);
                end
            end
            compare("R10 tone");
        end

        // R2 R3 R4 R8 R9 R11: random pulses, gaps and stray starts
        for (int p = 0; p < 60; p++) begin
            int len;
            len = 1 + ($urandom % (2 * NB + 6));
            put(1'b1, ($urandom % 8) != 0, int'($urandom % 256) - 128);
            for (int i = 1; i < len; i++) begin
                if (($urandom % 3) == 0) idle(1 + $urandom % 3);
                put(1'b1, ($urandom % 20) == 0, int'($urandom % 256) - 128);
            end
            if (p % 6 == 5) compare("R2 R3 R4 random");
        end
        compare("R2 R3 R11 random tail");

        summary();
        $finish;
    end
endmodule